// File: doc/BRIEF.md
# Fault-Injectable Bit-Wide RAM

This block is a single-port RAM, one bit wide, whose storage can be told at run time to misbehave in a chosen functional way. Its purpose is to act as the device under test for memory self-test logic: a march sequencer runs against it, and the result should flag exactly the fault that was switched on.

A configuration strobe captures a fault kind, a victim address, an aggressor address and two option bits. The fault kind is held in a small state machine. Its states are `FK_NONE`, `FK_STUCK`, `FK_TRANS`, `FK_CINV`, `FK_CIDEM`, `FK_CSTATE`, `FK_CDYN` and `FK_DECODE`. There is one transition rule: on any clock edge with the strobe high, the machine moves to the state named by `cfg_kind`. On any edge with the strobe low, it stays where it is. Reset returns it to `FK_NONE`. The option bits are `cfg_value` and `cfg_sel`. `cfg_value` is the forced, stuck or victim-state value. `cfg_sel` picks the transition direction (1 = rising) or the aggressor state.

Only one fault is active at a time. The storage cells are never reset. A free-running 16-bit LFSR supplies the random data that comes back when a cell that cannot be selected is read.

Top module: `flt_ram`

## Requirements
- R1: In state `FK_NONE` the block is a plain RAM. A read returns its data on `rd_bit` one clock after `rd_en`. `rd_bit` holds its value while `rd_en` is low and is 0 after reset. When `rd_en` and `wr_en` are both set, the read returns the value from before the write.
- R2: Fault settings are captured only on a clock edge with `cfg_strobe` high, and they act from the next cycle. `cfg_kind` is encoded 0 none, 1 stuck-at, 2 transition, 3 inversion coupling, 4 idempotent coupling, 5 state coupling, 6 dynamic coupling, 7 decoder.
- R3: Stuck-at: the victim cell always holds and reads as `cfg_value`, whatever is written to it.
- R4: Transition: with `cfg_sel`=1, a write that would move the victim from 0 to 1 is lost. With `cfg_sel`=0, a write from 1 to 0 is lost. Writes in the other direction still take effect.
- R5: Inversion coupling: a write that makes the aggressor rise (`cfg_sel`=1) or fall (`cfg_sel`=0) inverts the victim. A write in the other direction, or one that does not change the aggressor, leaves the victim alone.
- R6: Idempotent coupling: an aggressor transition in the `cfg_sel` direction sets the victim to `cfg_value`.
- R7: State coupling: while the aggressor cell holds `cfg_sel`, the victim reads as, and is held at, `cfg_value`. All four combinations work.
- R8: Dynamic coupling: any read or write of the aggressor address sets the victim cell to `cfg_value`.
- R9: Decoder fault: the victim address selects no cell, so writes to it are lost. The aggressor address selects both the aggressor and the victim cell. A write there stores into both, and a read there returns the AND of the two.
- R10: Decoder fault: a read of the victim address returns LFSR data. Within 32 consecutive such reads, both 0 and 1 appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the fault state, the LFSR and the read register |
| cfg_strobe | input | 1 | Capture the fault settings on this edge |
| cfg_kind | input | 3 | Fault kind (encoding in R2) |
| cfg_victim | input | AW | Victim cell address |
| cfg_aggr | input | AW | Aggressor cell address |
| cfg_value | input | 1 | Forced, stuck or victim-state value |
| cfg_sel | input | 1 | Transition direction (1 = rising) or aggressor state |
| addr | input | AW | Access address |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| wr_bit | input | 1 | Write data |
| rd_bit | output | 1 | Registered read data |

## Verification
The hardest case to reach is the group of coupling faults that depend on the aggressor's history. The inversion and idempotent cases need a write that actually changes the aggressor, in the chosen direction. The state case needs the aggressor to sit at the chosen value while the victim is written and read. The bench therefore first writes a known value to both cells. It then writes the aggressor through both directions, and also with a write that leaves it unchanged. The victim is read between every pair of steps. The state coupling case is swept over all four combinations of aggressor state and forced value. A behavioural model in the bench predicts each read, and the prediction is compared with `rd_bit` every cycle.

// File: rtl/flt_ram_pkg.sv
package flt_ram_pkg;

    typedef enum logic [2:0] {
        FK_NONE   = 3'd0,
        FK_STUCK  = 3'd1,
        FK_TRANS  = 3'd2,
        FK_CINV   = 3'd3,
        FK_CIDEM  = 3'd4,
        FK_CSTATE = 3'd5,
        FK_CDYN   = 3'd6,
        FK_DECODE = 3'd7
    } fault_kind_e;

    typedef struct packed {
        logic stuck;
        logic trans;
        logic cinv;
        logic cidem;
        logic cstate;
        logic cdyn;
        logic decode;
    } fault_flags_t;

    localparam int unsigned RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;
    localparam logic [15:0] RND_TAPS = 16'hB400;

endpackage

// File: rtl/flt_ram_cfg.sv
module flt_ram_cfg
    import flt_ram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [2:0]    kind_in,
    input  logic [AW-1:0] vic_in,
    input  logic [AW-1:0] agg_in,
    input  logic          val_in,
    input  logic          sel_in,
    output fault_kind_e   kind_q,
    output fault_flags_t  flags,
    output logic [AW-1:0] vic_q,
    output logic [AW-1:0] agg_q,
    output logic          val_q,
    output logic          sel_q
);

    fault_kind_e kind_nxt;

    always_comb begin
        kind_nxt = kind_q;
        if (strobe) begin
            kind_nxt = fault_kind_e'(kind_in);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= FK_NONE;
        end else begin
            kind_q <= kind_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vic_q <= '0;
            agg_q <= '0;
            val_q <= 1'b0;
            sel_q <= 1'b0;
        end else if (strobe) begin
            vic_q <= vic_in;
            agg_q <= agg_in;
            val_q <= val_in;
            sel_q <= sel_in;
        end
    end

    // outputs per state
    always_comb begin
        flags = '0;
        unique case (kind_q)
            FK_NONE:   ;
            FK_STUCK:  flags.stuck  = 1'b1;
            FK_TRANS:  flags.trans  = 1'b1;
            FK_CINV:   flags.cinv   = 1'b1;
            FK_CIDEM:  flags.cidem  = 1'b1;
            FK_CSTATE: flags.cstate = 1'b1;
            FK_CDYN:   flags.cdyn   = 1'b1;
            FK_DECODE: flags.decode = 1'b1;
        endcase
    end

endmodule

// File: rtl/flt_ram_lfsr.sv
module flt_ram_lfsr
    import flt_ram_pkg::*;
#(
    parameter int unsigned   W    = RND_W,
    parameter logic [W-1:0]  SEED = RND_SEED,
    parameter logic [W-1:0]  TAPS = RND_TAPS
) (
    input  logic clk,
    input  logic rst_n,
    output logic rnd
);

    logic [W-1:0] sr_q;
    logic         fb;

    assign fb  = ^(sr_q & TAPS);
    assign rnd = sr_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else begin
            sr_q <= {sr_q[W-2:0], fb};
        end
    end

endmodule

// File: rtl/flt_ram_array.sv
module flt_ram_array
    import flt_ram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                we,
    input  logic                re,
    input  logic                din,
    input  fault_flags_t        flags,
    input  logic [AW-1:0]       vic,
    input  logic [AW-1:0]       agg,
    input  logic                val,
    input  logic                sel,
    input  logic                rnd,
    output logic                dout,
    output logic [(1<<AW)-1:0]  cells
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DEPTH-1:0] mem_q;
    logic [DEPTH-1:0] mem_nxt;
    logic             hit_vic;
    logic             hit_agg;
    logic             agg_rise;
    logic             agg_fall;
    logic             agg_edge;
    logic             trans_block;
    logic             rd_val;

    assign cells    = mem_q;
    assign hit_vic  = (addr == vic);
    assign hit_agg  = (addr == agg);
    assign agg_rise = we && hit_agg && !mem_q[agg] &&  din;
    assign agg_fall = we && hit_agg &&  mem_q[agg] && !din;
    assign agg_edge = sel ? agg_rise : agg_fall;
    assign trans_block = hit_vic &&
                         (sel ? (!mem_q[vic] && din) : (mem_q[vic] && !din));

    // write path and fault effects on the stored cells
    always_comb begin
        mem_nxt = mem_q;
        if (we) begin
            if (flags.decode) begin
                if (hit_agg) begin
                    mem_nxt[agg] = din;
                    mem_nxt[vic] = din;
                end else if (!hit_vic) begin
                    mem_nxt[addr] = din;
                end
            end else if (!(flags.trans && trans_block)) begin
                mem_nxt[addr] = din;
            end
        end
        if (flags.stuck) begin
            mem_nxt[vic] = val;
        end
        if (flags.cinv && agg_edge) begin
            mem_nxt[vic] = ~mem_q[vic];
        end
        if (flags.cidem && agg_edge) begin
            mem_nxt[vic] = val;
        end
        if (flags.cdyn && hit_agg && (we || re)) begin
            mem_nxt[vic] = val;
        end
        if (flags.cstate && (mem_nxt[agg] == sel)) begin
            mem_nxt[vic] = val;
        end
    end

    // the cells are deliberately left without reset
    always_ff @(posedge clk) begin
        mem_q <= mem_nxt;
    end

    // read path
    always_comb begin
        rd_val = mem_q[addr];
        if (flags.decode && hit_vic) begin
            rd_val = rnd;
        end else if (flags.decode && hit_agg) begin
            rd_val = mem_q[agg] & mem_q[vic];
        end else if (flags.stuck && hit_vic) begin
            rd_val = val;
        end else if (flags.cstate && hit_vic && (mem_q[agg] == sel)) begin
            rd_val = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (re) begin
            dout <= rd_val;
        end
    end

endmodule

// File: rtl/flt_ram.sv
module flt_ram
    import flt_ram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_strobe,
    input  logic [2:0]    cfg_kind,
    input  logic [AW-1:0] cfg_victim,
    input  logic [AW-1:0] cfg_aggr,
    input  logic          cfg_value,
    input  logic          cfg_sel,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          wr_bit,
    output logic          rd_bit
);

    localparam int unsigned DEPTH = 1 << AW;

    fault_kind_e      kind_q;
    fault_flags_t     flags;
    logic [AW-1:0]    vic_q;
    logic [AW-1:0]    agg_q;
    logic             val_q;
    logic             sel_q;
    logic             rnd;
    logic [DEPTH-1:0] cells;

    flt_ram_cfg #(.AW(AW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (cfg_strobe),
        .kind_in (cfg_kind),
        .vic_in  (cfg_victim),
        .agg_in  (cfg_aggr),
        .val_in  (cfg_value),
        .sel_in  (cfg_sel),
        .kind_q  (kind_q),
        .flags   (flags),
        .vic_q   (vic_q),
        .agg_q   (agg_q),
        .val_q   (val_q),
        .sel_q   (sel_q)
    );

    flt_ram_lfsr u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    flt_ram_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .we    (wr_en),
        .re    (rd_en),
        .din   (wr_bit),
        .flags (flags),
        .vic   (vic_q),
        .agg   (agg_q),
        .val   (val_q),
        .sel   (sel_q),
        .rnd   (rnd),
        .dout  (rd_bit),
        .cells (cells)
    );

endmodule

// File: rtl/flt_ram_chk.sv
module flt_ram_chk
    import flt_ram_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_strobe,
    input logic [AW-1:0]       addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic                rd_bit,
    input fault_kind_e         kind_q,
    input fault_flags_t        flags,
    input logic [AW-1:0]       vic_q,
    input logic [AW-1:0]       agg_q,
    input logic                val_q,
    input logic [(1<<AW)-1:0]  cells
);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_bit));

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_strobe |=> $stable(kind_q) && $stable(vic_q) && $stable(agg_q));

    a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    a_r3_stuck_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == FK_STUCK && !cfg_strobe) |=> cells[vic_q] == val_q);

    a_r3_stuck_read: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == FK_STUCK && !cfg_strobe && rd_en && addr == vic_q)
        |=> rd_bit == val_q);

    a_r8_dyn_force: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == FK_CDYN && !cfg_strobe && (wr_en || rd_en) && addr == agg_q)
        |=> cells[vic_q] == val_q);

    a_r9_dec_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == FK_DECODE && !cfg_strobe && wr_en && addr == vic_q &&
         vic_q != agg_q) |=> $stable(cells));

endmodule

bind flt_ram flt_ram_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_strobe (cfg_strobe),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_bit     (rd_bit),
    .kind_q     (kind_q),
    .flags      (flags),
    .vic_q      (vic_q),
    .agg_q      (agg_q),
    .val_q      (val_q),
    .cells      (cells)
);

// File: tb/flt_ram_tb.sv
module flt_ram_tb;

    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_strobe = 1'b0;
    logic [2:0]    cfg_kind = '0;
    logic [AW-1:0] cfg_victim = '0;
    logic [AW-1:0] cfg_aggr = '0;
    logic          cfg_value = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_bit = 1'b0;
    logic          rd_bit;

    always #2 clk = ~clk;

    flt_ram #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .cfg_kind(cfg_kind),
        .cfg_victim(cfg_victim), .cfg_aggr(cfg_aggr), .cfg_value(cfg_value),
        .cfg_sel(cfg_sel), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_bit(wr_bit), .rd_bit(rd_bit)
    );

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string req = "R1";

    // behavioural model state
    bit m [N];
    int k = 0, v = 0, g = 0;
    bit fv = 0, fs = 0;
    bit exp_q = 0;
    bit exp_rand = 0;
    int seen0 = 0, seen1 = 0;

    task automatic check(input bit got, input bit want, input string what);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, want);
        end
    endtask

    // one access cycle: model predicts, DUT is compared at the following negedge
    task automatic cyc(input bit w, input bit r, input int a, input bit d);
        bit pre [N];
        bit nxt [N];
        bit rv;
        bit rr;
        bit edge_ok;
        pre = m;
        nxt = m;
        rr = 0;
        rv = pre[a];
        if (k == 7 && a == v)                    rr = 1;
        else if (k == 7 && a == g)               rv = pre[g] & pre[v];
        else if (k == 1 && a == v)               rv = fv;
        else if (k == 5 && a == v && pre[g] == fs) rv = fv;
        if (w) begin
            if (k == 7) begin
                if (a == g) begin nxt[g] = d; nxt[v] = d; end
                else if (a != v) nxt[a] = d;
            end else if (k == 2 && a == v &&
                         ((fs && !pre[a] && d) || (!fs && pre[a] && !d))) begin
                nxt[a] = pre[a];
            end else begin
                nxt[a] = d;
            end
        end
        edge_ok = w && a == g && (fs ? (!pre[g] && d) : (pre[g] && !d));
        if (k == 1) nxt[v] = fv;
        if (k == 3 && edge_ok) nxt[v] = !pre[v];
        if (k == 4 && edge_ok) nxt[v] = fv;
        if (k == 6 && a == g && (w || r)) nxt[v] = fv;
        if (k == 5 && nxt[g] == fs) nxt[v] = fv;
        wr_en = w; rd_en = r; addr = a[AW-1:0]; wr_bit = d;
        @(posedge clk);
        #1;
        m = nxt;
        if (r) begin exp_q = rv; exp_rand = rr; end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        if (exp_rand) begin
            if (r) begin
                if (rd_bit) seen1++; else seen0++;
            end
        end else begin
            check(rd_bit, exp_q, $sformatf("rd_bit after access to %0d", a));
        end
    endtask

    task automatic wr(input int a, input bit d); cyc(1, 0, a, d); endtask
    task automatic rd(input int a); cyc(0, 1, a, 0); endtask
    task automatic idle(); cyc(0, 0, 0, 0); endtask

    task automatic set_fault(input int kk, input int vv, input int gg,
                             input bit val, input bit sel);
        cfg_strobe = 1; cfg_kind = kk[2:0]; cfg_victim = vv[AW-1:0];
        cfg_aggr = gg[AW-1:0]; cfg_value = val; cfg_sel = sel;
        cyc(0, 0, 0, 0);
        cfg_strobe = 0;
        k = kk; v = vv; g = gg; fv = val; fs = sel;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        check(rd_bit, 0, "reset value");
        rst_n = 1;
        @(negedge clk);
        // R1 plain RAM: fill and read back
        for (int i = 0; i < N; i++) wr(i, bit'((i * 5) >> 1));
        for (int i = 0; i < N; i++) rd(i);
        for (int i = 0; i < N; i++) wr(i, bit'(i % 2 == 0));
        for (int i = N - 1; i >= 0; i--) rd(i);
        idle(); idle();                      // R1 hold while rd_en low
        cyc(1, 1, 3, !m[3]);                 // R1 read-before-write
        rd(3);

        // R2: settings without strobe are ignored
        req = "R2";
        cfg_kind = 3'd1; cfg_victim = 4'd3; cfg_value = 0;
        wr(3, 1); rd(3); wr(3, 0); rd(3); wr(3, 1); rd(3);
        cfg_kind = 3'd0;

        // R3 stuck-at both polarities
        req = "R3";
        set_fault(1, 5, 0, 0, 0);
        rd(5); wr(5, 1); rd(5); wr(6, 1); rd(6);
        set_fault(1, 5, 0, 1, 0);
        rd(5); wr(5, 0); rd(5);

        // R4 transition faults
        req = "R4";
        set_fault(0, 0, 0, 0, 0);
        wr(6, 0);
        set_fault(2, 6, 0, 0, 1);            // rising blocked
        wr(6, 1); rd(6); wr(7, 1); rd(7);
        set_fault(0, 0, 0, 0, 0);
        wr(6, 1);
        set_fault(2, 6, 0, 0, 1);
        wr(6, 0); rd(6); wr(6, 1); rd(6);
        set_fault(2, 6, 0, 0, 0);            // falling blocked
        wr(6, 0); rd(6); wr(6, 1); rd(6);

        // R5 inversion coupling, both directions
        req = "R5";
        set_fault(0, 0, 0, 0, 0);
        wr(2, 0); wr(9, 0);
        set_fault(3, 9, 2, 0, 1);
        wr(2, 0); rd(9); wr(2, 1); rd(9); wr(2, 1); rd(9);
        wr(2, 0); rd(9); wr(2, 1); rd(9);
        set_fault(3, 9, 2, 0, 0);
        wr(2, 0); rd(9); wr(2, 1); rd(9); wr(2, 0); rd(9);

        // R6 idempotent coupling
        req = "R6";
        set_fault(4, 10, 1, 1, 1);
        wr(1, 0); wr(10, 0); rd(10); wr(1, 1); rd(10);
        wr(10, 0); wr(1, 0); rd(10);
        set_fault(4, 10, 1, 0, 0);
        wr(10, 1); wr(1, 1); rd(10); wr(1, 0); rd(10);

        // R7 state coupling, all four combinations
        req = "R7";
        for (int y = 0; y < 2; y++) begin
            for (int x = 0; x < 2; x++) begin
                set_fault(0, 0, 0, 0, 0);
                wr(11, !x[0]); wr(12, !y[0]);
                set_fault(5, 11, 12, x[0], y[0]);
                rd(11); wr(11, !x[0]); rd(11);
                wr(12, y[0]); rd(11); wr(11, !x[0]); rd(11); rd(12);
                wr(12, !y[0]); wr(11, !x[0]); rd(11);
            end
        end

        // R8 dynamic coupling
        req = "R8";
        set_fault(6, 13, 14, 1, 0);
        wr(13, 0); rd(13); rd(14); rd(13);
        set_fault(6, 13, 14, 0, 0);
        wr(13, 1); rd(13); wr(14, 1); rd(13); rd(14);

        // R9 decoder fault
        req = "R9";
        set_fault(0, 0, 0, 0, 0);
        wr(4, 0); wr(15, 1);
        set_fault(7, 4, 15, 0, 0);
        wr(4, 1); rd(15); wr(15, 0); wr(15, 1); rd(15);
        set_fault(0, 0, 0, 0, 0);
        rd(4); rd(15);
        wr(4, 0);
        set_fault(7, 4, 15, 0, 0);
        rd(15); rd(8);

        // R10 random data from the unselectable address
        req = "R10";
        seen0 = 0; seen1 = 0;
        for (int i = 0; i < 32; i++) rd(4);
        total++;
        if (seen0 == 0 || seen1 == 0) begin
            bad++;
            $display("FAIL R10 random reads: got zeros=%0d ones=%0d expected both nonzero",
                     seen0, seen1);
        end
        rd(15);

        // back to fault-free operation
        req = "R1";
        set_fault(0, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) wr(i, bit'(i % 3 == 0));
        for (int i = 0; i < N; i++) rd(i);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule